// File: doc/BRIEF.md
# Indexed PLL Configuration Update Controller

This block holds the working settings of several PLLs behind one small set of shared registers. Software first names a target PLL by writing its index, with the commit bit clear. It then fills a single staging area with an integer multiplier, a fractional multiplier, two divider ratios and four enable bits. Nothing reaches a PLL until software writes the commit bit as 1 with the same index. That write copies the staged values into the target PLL's active set in one step.

The active sets come out as flat per-PLL vectors. Among them are the clock-gate enables for each PLL's system clock path and IO clock path. The analog PLLs and the clock dividers sit outside this block; the divider ratios are only passed through as values. A start-up time field is also kept here. It is write-protected while any PLL is running, so the value cannot move under a PLL in the middle of a start.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: After reset, every active multiplier, fraction, divider and enable is 0, every clock gate is closed, the start-up time is 0 and the latched index is 0.
- R2: A write to address 0 with bit 8 clear latches bits [IDX_W-1:0] as the index. Reading address 0 returns the latched index in bits [IDX_W-1:0] and the start-up time in bits [16 +: STUP_W]. Bit 8 always reads as 0.
- R3: A write to address 0 with bit 8 set, and bits [IDX_W-1:0] equal to the latched index, commits the staged fields into that PLL's active set. The new values appear on the outputs after the clock edge that takes the write. No other PLL's set changes. The staged fields are: address 1 holds the multiplier in [MUL_W-1:0] and the fraction in [16 +: FRAC_W]; address 2 holds the system divider in [DIV_W-1:0], the IO divider in [8 +: DIV_W], and, in bits 16, 17, 18 and 19, the PLL enable, the lock-detect enable, the system gate enable and the IO gate enable.
- R4: A commit write whose index differs from the latched index is cancelled, and no active value changes.
- R5: A commit for an index of NUM_PLL or more is cancelled, and no active value changes.
- R6: The start-up field of an index write (address 0, bit 8 clear) is stored only while every active PLL enable is 0. At any other time it is ignored.
- R7: Writing staged gate enables, or any other staged field, changes no output until a commit.
- R8: A gate enable is stored as 1 only if the same commit also sets the PLL enable. A commit that clears the PLL enable therefore closes both gates.
- R9: A PLL that is already enabled and gated accepts new multiplier and divider values through a commit, and its gates stay open.
- R10: The IO gate of a PLL whose bit in HAS_IO is 0 stays 0 under any commit. PLLs whose bit is 1 follow the staged value.
- R11: Reading addresses 1 and 2 returns the active values of the latched PLL, in the staging layout of R3. For an out-of-range latched index the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| act_mul | output | NUM_PLL*MUL_W | Active integer multipliers, PLL i at [i*MUL_W +: MUL_W] |
| act_frac | output | NUM_PLL*FRAC_W | Active fractional multipliers |
| act_div_sys | output | NUM_PLL*DIV_W | Active system-clock dividers |
| act_div_io | output | NUM_PLL*DIV_W | Active IO-clock dividers |
| act_pll_en | output | NUM_PLL | Active PLL enables |
| act_lock_en | output | NUM_PLL | Active lock-detect enables |
| sys_gate | output | NUM_PLL | System clock-gate enables |
| io_gate | output | NUM_PLL | IO clock-gate enables |
| startup_time | output | STUP_W | Start-up time value |

## Verification
Each register write takes effect at the one clock edge that samples it. Latched index, start-up time, staged fields and committed active values are all visible one edge after the write. Read data is combinational on the address. Writes are driven on a falling edge and withdrawn on the next falling edge, and outputs are sampled at that second falling edge, just after the edge that acted on the write. Cancelled commits and ignored start-up writes are checked at the same point, by confirming that the outputs and the readback still hold their earlier values.

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl #(
  parameter int NUM_PLL = 3,
  parameter int IDX_W   = 2,
  parameter int MUL_W   = 8,
  parameter int FRAC_W  = 12,
  parameter int DIV_W   = 4,
  parameter int STUP_W  = 8,
  parameter logic [NUM_PLL-1:0] HAS_IO = 3'b101
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [1:0]                bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_PLL*MUL_W-1:0]  act_mul,
  output logic [NUM_PLL*FRAC_W-1:0] act_frac,
  output logic [NUM_PLL*DIV_W-1:0]  act_div_sys,
  output logic [NUM_PLL*DIV_W-1:0]  act_div_io,
  output logic [NUM_PLL-1:0]        act_pll_en,
  output logic [NUM_PLL-1:0]        act_lock_en,
  output logic [NUM_PLL-1:0]        sys_gate,
  output logic [NUM_PLL-1:0]        io_gate,
  output logic [STUP_W-1:0]         startup_time
);
  localparam int CMT_BIT   = 8;
  localparam int STUP_LSB  = 16;
  localparam int FRAC_LSB  = 16;
  localparam int DIO_LSB   = 8;
  localparam int EN_LSB    = 16;

  logic [IDX_W-1:0]  lat_idx;
  logic [MUL_W-1:0]  st_mul;
  logic [FRAC_W-1:0] st_frac;
  logic [DIV_W-1:0]  st_dsys, st_dio;
  logic [3:0]        st_en;

  logic [MUL_W-1:0]  a_mul  [NUM_PLL];
  logic [FRAC_W-1:0] a_frac [NUM_PLL];
  logic [DIV_W-1:0]  a_dsys [NUM_PLL];
  logic [DIV_W-1:0]  a_dio  [NUM_PLL];
  logic [NUM_PLL-1:0] hit;

  wire [IDX_W-1:0] w_idx   = bus_wdata[IDX_W-1:0];
  wire             wr_upd  = bus_wr && bus_addr == 2'd0;
  wire             do_lat  = wr_upd && !bus_wdata[CMT_BIT];
  wire             do_cmt  = wr_upd && bus_wdata[CMT_BIT] && w_idx == lat_idx;
  wire             all_off = act_pll_en == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_idx      <= '0;
      startup_time <= '0;
      st_mul       <= '0;
      st_frac      <= '0;
      st_dsys      <= '0;
      st_dio       <= '0;
      st_en        <= '0;
    end else begin
      if (do_lat) begin
        lat_idx <= w_idx;
        if (all_off) startup_time <= bus_wdata[STUP_LSB +: STUP_W];
      end
      if (bus_wr && bus_addr == 2'd1) begin
        st_mul  <= bus_wdata[MUL_W-1:0];
        st_frac <= bus_wdata[FRAC_LSB +: FRAC_W];
      end
      if (bus_wr && bus_addr == 2'd2) begin
        st_dsys <= bus_wdata[DIV_W-1:0];
        st_dio  <= bus_wdata[DIO_LSB +: DIV_W];
        st_en   <= bus_wdata[EN_LSB +: 4];
      end
    end
  end

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
    assign hit[i] = lat_idx == IDX_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_mul[i]       <= '0;
        a_frac[i]      <= '0;
        a_dsys[i]      <= '0;
        a_dio[i]       <= '0;
        act_pll_en[i]  <= 1'b0;
        act_lock_en[i] <= 1'b0;
        sys_gate[i]    <= 1'b0;
        io_gate[i]     <= 1'b0;
      end else if (do_cmt && hit[i]) begin
        a_mul[i]       <= st_mul;
        a_frac[i]      <= st_frac;
        a_dsys[i]      <= st_dsys;
        a_dio[i]       <= st_dio;
        act_pll_en[i]  <= st_en[0];
        act_lock_en[i] <= st_en[1];
        sys_gate[i]    <= st_en[0] & st_en[2];
        io_gate[i]     <= st_en[0] & st_en[3] & HAS_IO[i];
      end
    end
    assign act_mul[i*MUL_W +: MUL_W]    = a_mul[i];
    assign act_frac[i*FRAC_W +: FRAC_W] = a_frac[i];
    assign act_div_sys[i*DIV_W +: DIV_W] = a_dsys[i];
    assign act_div_io[i*DIV_W +: DIV_W]  = a_dio[i];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: begin
        bus_rdata[IDX_W-1:0]           = lat_idx;
        bus_rdata[STUP_LSB +: STUP_W]  = startup_time;
      end
      2'd1, 2'd2: begin
        for (int i = 0; i < NUM_PLL; i++) begin
          if (hit[i]) begin
            if (bus_addr == 2'd1) begin
              bus_rdata[MUL_W-1:0]          = a_mul[i];
              bus_rdata[FRAC_LSB +: FRAC_W] = a_frac[i];
            end else begin
              bus_rdata[DIV_W-1:0]       = a_dsys[i];
              bus_rdata[DIO_LSB +: DIV_W] = a_dio[i];
              bus_rdata[EN_LSB +: 4]     = {io_gate[i], sys_gate[i], act_lock_en[i], act_pll_en[i]};
            end
          end
        end
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_CANCEL_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd && bus_wdata[CMT_BIT] && w_idx != lat_idx) |=> ($stable(act_mul) && $stable(act_pll_en) && $stable(sys_gate) && $stable(io_gate))); // R4
  AST_STUP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd && act_pll_en != '0) |=> $stable(startup_time)); // R6
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(act_mul) && $stable(act_frac) && $stable(act_pll_en) && $stable(sys_gate))); // R7
  AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((sys_gate | io_gate) & ~act_pll_en) == '0); // R8
  AST_NO_IO_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (io_gate & ~HAS_IO) == '0); // R10
  AST_CMT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd0 |-> !bus_rdata[CMT_BIT]); // R2
endmodule

// File: tb/pll_cfg_ctrl_test.sv
module pll_cfg_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] act_mul;
  logic [35:0] act_frac;
  logic [11:0] act_div_sys, act_div_io;
  logic [2:0]  act_pll_en, act_lock_en, sys_gate, io_gate;
  logic [7:0]  startup_time;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_cfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_mul(act_mul),
    .act_frac(act_frac), .act_div_sys(act_div_sys), .act_div_io(act_div_io),
    .act_pll_en(act_pll_en), .act_lock_en(act_lock_en), .sys_gate(sys_gate),
    .io_gate(io_gate), .startup_time(startup_time)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 mul", 64'(act_mul), 0);
    check("R1 en", 64'({act_pll_en, act_lock_en, sys_gate, io_gate}), 0);
    check("R1 startup", 64'(startup_time), 0);
    rd(2'd0, d);
    check("R1 readback", 64'(d), 0);
  endtask

  task automatic t_commit;
    logic [31:0] d;
    wr(2'd0, 32'h0020_0001);
    check("R6 startup taken", 64'(startup_time), 64'h20);
    rd(2'd0, d);
    check("R2 index read", 64'(d), 64'h0020_0001);
    wr(2'd1, 32'h0155_0032);
    wr(2'd2, 32'h000F_0503);
    check("R7 staged only", 64'({act_mul, act_pll_en, sys_gate, io_gate}), 0);
    wr(2'd0, 32'h0000_0101);
    check("R3 mul", 64'(act_mul), 64'h00_32_00);
    check("R3 frac", 64'(act_frac[23:12]), 64'h155);
    check("R3 div", 64'({act_div_sys[7:4], act_div_io[7:4]}), 64'h35);
    check("R3 enables", 64'({act_pll_en, act_lock_en, sys_gate}), 64'({3'b010, 3'b010, 3'b010}));
    check("R10 no io path", 64'(io_gate), 0);
    rd(2'd0, d);
    check("R2 commit bit reads 0", 64'(d[8]), 0);
    rd(2'd1, d);
    check("R11 read mul/frac", 64'(d), 64'h0155_0032);
    rd(2'd2, d);
    check("R11 read ctrl", 64'(d), 64'h0007_0503);
  endtask

  task automatic t_startup_lock;
    wr(2'd0, 32'h0055_0001);
    check("R6 startup protected", 64'(startup_time), 64'h20);
  endtask

  task automatic t_mismatch;
    wr(2'd1, 32'h0155_0040);
    wr(2'd0, 32'h0000_0102);
    check("R4 cancel mul", 64'(act_mul), 64'h00_32_00);
    check("R4 cancel en", 64'({act_pll_en, sys_gate}), 64'({3'b010, 3'b010}));
  endtask

  task automatic t_reconfig;
    wr(2'd0, 32'h0000_0101);
    check("R9 new mul", 64'(act_mul), 64'h00_40_00);
    check("R9 gates held", 64'({act_pll_en, sys_gate}), 64'({3'b010, 3'b010}));
  endtask

  task automatic t_io_path;
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h0000_0007);
    wr(2'd2, 32'h000F_0201);
    wr(2'd0, 32'h0000_0100);
    check("R10 io gate opens", 64'(io_gate), 64'b001);
    check("R3 pll0 others kept", 64'({act_mul, sys_gate}), 64'({24'h00_40_07, 3'b011}));
  endtask

  task automatic t_out_of_range;
    logic [31:0] d;
    wr(2'd0, 32'h0000_0003);
    wr(2'd0, 32'h0000_0103);
    check("R5 cancel", 64'({act_mul, act_pll_en, sys_gate, io_gate}), 64'({24'h00_40_07, 3'b011, 3'b011, 3'b001}));
    rd(2'd1, d);
    check("R11 out of range reads 0", 64'(d), 0);
  endtask

  task automatic t_disable;
    wr(2'd0, 32'h0000_0001);
    wr(2'd2, 32'h0003_0503);
    wr(2'd0, 32'h0000_0101);
    check("R3 gates closed first", 64'({act_pll_en, sys_gate}), 64'({3'b011, 3'b001}));
    wr(2'd2, 32'h0000_0503);
    wr(2'd0, 32'h0000_0101);
    check("R3 pll off", 64'(act_pll_en), 64'b001);
  endtask

  task automatic t_gate_needs_en;
    wr(2'd0, 32'h0000_0002);
    wr(2'd2, 32'h000C_0000);
    wr(2'd0, 32'h0000_0102);
    check("R8 gates need enable", 64'({sys_gate[2], io_gate[2], act_pll_en[2]}), 0);
    wr(2'd0, 32'h0000_0000);
    wr(2'd2, 32'h000C_0000);
    wr(2'd0, 32'h0000_0100);
    check("R8 clear enable closes gates", 64'({act_pll_en, sys_gate, io_gate}), 0);
    wr(2'd0, 32'h0077_0000);
    check("R6 startup after all off", 64'(startup_time), 64'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_startup_lock();
    t_mismatch();
    t_reconfig();
    t_io_path();
    t_out_of_range();
    t_disable();
    t_gate_needs_en();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule